// File: doc/BRIEF.md
# Interleaved Bank Request Steering Front End

This block sits between two request ports and a set of single-ported storage banks, so that a cache can take more than one access per cycle without a multi-ported array. Each request's bank is taken from the address at block granularity: the bank field is the group of bits just above the block offset, which makes the bank number equal to the block address modulo the bank count. Requests to distinct banks issue together in the same cycle. Requests to the same bank collide, and then only one of them goes ahead.

Port 0 always wins a collision. The losing request from a lower-priority port is captured inside the block. That port's ready output then drops, and the held request issues again in the following cycle, ahead of anything new the port presents. Each bank stores one data word per block in a simple internal array. A read returns its word on the originating port's response channel one cycle after the grant. The command each bank executes in a cycle is visible on that bank's command bus.

Top module: `ilv_bank_front`

## Requirements
- R1: The bank of a request is address bits [7:6] for the default 64-byte block and 4 banks, i.e. (address/64) mod 4. The word index within the bank is address bits [15:8]. The offset bits [5:0] affect neither.
- R2: Two valid requests to different banks are both granted in the same cycle.
- R3: When both ports target the same bank, port 0 is granted and port 1 is not. A valid request on port 0 is always granted in the cycle it is presented.
- R4: A request that loses arbitration is held. The port's ready is low in the next cycle, and the held request competes again in that cycle. Ready returns high after the cycle in which the held request is granted.
- R5: While a port's ready is low, its request inputs are ignored. Only the held request issues, and the ignored write does not change storage.
- R6: A granted read produces rsp_valid for its own port exactly one clock later, carrying the data of the addressed word.
- R7: A read of a word after a write to the same bank and index returns the written data.
- R8: During and right after reset, both ready outputs are high, and no grant, bank command or response is active while the inputs are idle.
- R9: bk_valid[b] is high exactly when a request is granted to bank b. The bank's command bus then shows its write flag, word index, write data and the port number of the winner (port 0 = 0, port 1 = 1), and the number of active banks equals the number of grants.
- R10: A granted write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPORT | Request valid, bit p for port p |
| req_addr | input | NPORT*ADDR_W | Byte address, port p in slice p |
| req_we | input | NPORT | 1 = write, 0 = read |
| req_wdata | input | NPORT*DATA_W | Write data per port |
| req_ready | output | NPORT | Port may present a new request |
| req_grant | output | NPORT | Port's request issued to its bank this cycle |
| rsp_valid | output | NPORT | Read data valid for port p |
| rsp_data | output | NPORT*DATA_W | Read data per port |
| bk_valid | output | NBANK | Bank b executes a command this cycle |
| bk_we | output | NBANK | Write flag per bank |
| bk_idx | output | NBANK*IDX_W | Word index per bank |
| bk_wdata | output | NBANK*DATA_W | Write data per bank |
| bk_port | output | NBANK*PID_W | Winning port number per bank |

## Verification
A wrong hold register would show in the cycle after a collision. Either ready would stay high, or the bank bus would show the port's newly presented address in place of the held one. The stale write would then come back on a later read of the overwritten word. A wrong bank field or priority shows at once on bk_valid and req_grant in the same cycle as the request. A wrong response path shows one cycle later as a missing rsp_valid or the wrong word on the wrong port.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // width of an identifier for n items, never below one bit
  function automatic int id_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ilv_port_hold.sv
module ilv_port_hold #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  input  logic          in_we,
  input  logic [DW-1:0] in_wdata,
  input  logic          won,
  output logic          eff_valid,
  output logic [AW-1:0] eff_addr,
  output logic          eff_we,
  output logic [DW-1:0] eff_wdata,
  output logic          ready
);
  logic          pend_v;
  logic [AW-1:0] pend_addr;
  logic          pend_we;
  logic [DW-1:0] pend_wdata;

  // a held request takes the place of whatever the port presents
  assign eff_valid = pend_v | in_valid;
  assign eff_addr  = pend_v ? pend_addr  : in_addr;
  assign eff_we    = pend_v ? pend_we    : in_we;
  assign eff_wdata = pend_v ? pend_wdata : in_wdata;
  assign ready     = ~pend_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
    end else begin
      pend_v <= eff_valid & ~won;
    end
    if (!pend_v) begin
      pend_addr  <= in_addr;
      pend_we    <= in_we;
      pend_wdata <= in_wdata;
    end
  end
endmodule

// File: rtl/ilv_bank_arb.sv
module ilv_bank_arb #(
  parameter int NPORT  = 2,
  parameter int NBANK  = 4,
  parameter int BSEL_W = 2,
  parameter int PID_W  = 1
) (
  input  logic [NPORT-1:0]        eff_valid,
  input  logic [NPORT*BSEL_W-1:0] eff_bank,
  output logic [NPORT-1:0]        won,
  output logic [NBANK-1:0]        sel_v,
  output logic [NBANK*PID_W-1:0]  sel_port
);
  // lowest port index wins each bank
  always_comb begin
    won      = '0;
    sel_v    = '0;
    sel_port = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (eff_valid[p] && !sel_v[eff_bank[p*BSEL_W +: BSEL_W]]) begin
        won[p] = 1'b1;
        sel_v[eff_bank[p*BSEL_W +: BSEL_W]] = 1'b1;
        sel_port[eff_bank[p*BSEL_W +: BSEL_W]*PID_W +: PID_W] = PID_W'(p);
      end
    end
  end
endmodule

// File: rtl/ilv_bank_ram.sv
module ilv_bank_ram #(
  parameter int IDX_W = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             cmd_v,
  input  logic             cmd_we,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic [DW-1:0]    cmd_wdata,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [2**IDX_W];

  always_ff @(posedge clk) begin
    if (cmd_v) begin
      if (cmd_we) mem[cmd_idx] <= cmd_wdata;
      rdata <= mem[cmd_idx];
    end
  end
endmodule

// File: rtl/ilv_bank_front.sv
module ilv_bank_front #(
  parameter int NPORT     = 2,
  parameter int NBANK     = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int BLK_BYTES = 64,
  localparam int OFF_W  = $clog2(BLK_BYTES),
  localparam int BSEL_W = ilv_pkg::id_width(NBANK),
  localparam int IDX_W  = ADDR_W - OFF_W - BSEL_W,
  localparam int PID_W  = ilv_pkg::id_width(NPORT)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPORT-1:0]        req_valid,
  input  logic [NPORT*ADDR_W-1:0] req_addr,
  input  logic [NPORT-1:0]        req_we,
  input  logic [NPORT*DATA_W-1:0] req_wdata,
  output logic [NPORT-1:0]        req_ready,
  output logic [NPORT-1:0]        req_grant,
  output logic [NPORT-1:0]        rsp_valid,
  output logic [NPORT*DATA_W-1:0] rsp_data,
  output logic [NBANK-1:0]        bk_valid,
  output logic [NBANK-1:0]        bk_we,
  output logic [NBANK*IDX_W-1:0]  bk_idx,
  output logic [NBANK*DATA_W-1:0] bk_wdata,
  output logic [NBANK*PID_W-1:0]  bk_port
);
  logic [NPORT-1:0]        eff_valid;
  logic [NPORT-1:0]        eff_we;
  logic [ADDR_W-1:0]       eff_addr  [NPORT];
  logic [DATA_W-1:0]       eff_wdata [NPORT];
  logic [NPORT*BSEL_W-1:0] eff_bank;
  logic [NPORT-1:0]        won;
  logic [DATA_W-1:0]       bk_rdata  [NBANK];
  logic [BSEL_W-1:0]       rsp_bank  [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    ilv_port_hold #(.AW(ADDR_W), .DW(DATA_W)) u_hold (
      .clk      (clk),
      .rst      (rst),
      .in_valid (req_valid[p]),
      .in_addr  (req_addr[p*ADDR_W +: ADDR_W]),
      .in_we    (req_we[p]),
      .in_wdata (req_wdata[p*DATA_W +: DATA_W]),
      .won      (won[p]),
      .eff_valid(eff_valid[p]),
      .eff_addr (eff_addr[p]),
      .eff_we   (eff_we[p]),
      .eff_wdata(eff_wdata[p]),
      .ready    (req_ready[p])
    );

    assign eff_bank[p*BSEL_W +: BSEL_W] = eff_addr[p][OFF_W +: BSEL_W];

    always_ff @(posedge clk) begin
      if (rst) rsp_valid[p] <= 1'b0;
      else     rsp_valid[p] <= won[p] & ~eff_we[p];
      if (won[p]) rsp_bank[p] <= eff_addr[p][OFF_W +: BSEL_W];
    end

    assign rsp_data[p*DATA_W +: DATA_W] = bk_rdata[rsp_bank[p]];
  end

  ilv_bank_arb #(
    .NPORT(NPORT), .NBANK(NBANK), .BSEL_W(BSEL_W), .PID_W(PID_W)
  ) u_arb (
    .eff_valid(eff_valid),
    .eff_bank (eff_bank),
    .won      (won),
    .sel_v    (bk_valid),
    .sel_port (bk_port)
  );

  assign req_grant = won;

  // route each bank's winner onto its command bus
  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      bk_we[b] = bk_valid[b] & eff_we[bk_port[b*PID_W +: PID_W]];
      bk_idx[b*IDX_W +: IDX_W] =
        eff_addr[bk_port[b*PID_W +: PID_W]][ADDR_W-1 -: IDX_W];
      bk_wdata[b*DATA_W +: DATA_W] = eff_wdata[bk_port[b*PID_W +: PID_W]];
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ilv_bank_ram #(.IDX_W(IDX_W), .DW(DATA_W)) u_ram (
      .clk      (clk),
      .cmd_v    (bk_valid[b]),
      .cmd_we   (bk_we[b]),
      .cmd_idx  (bk_idx[b*IDX_W +: IDX_W]),
      .cmd_wdata(bk_wdata[b*DATA_W +: DATA_W]),
      .rdata    (bk_rdata[b])
    );
  end
endmodule

// File: rtl/ilv_bank_front_chk.sv
module ilv_bank_front_chk #(
  parameter int NPORT = 2,
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NPORT-1:0] req_valid,
  input logic [NPORT-1:0] req_ready,
  input logic [NPORT-1:0] req_grant,
  input logic [NPORT-1:0] rsp_valid,
  input logic [NBANK-1:0] bk_valid
);
  // R3: the top-priority port is never refused
  p_top_prio_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid[0] |-> req_grant[0]);

  // R9: one active bank per grant
  p_bank_count_r9: assert property (@(posedge clk) disable iff (rst)
    $countones(bk_valid) == $countones(req_grant));

  for (genvar p = 0; p < NPORT; p++) begin : g_p
    // R4: an accepted but refused request stalls the port next cycle
    p_lose_stall_r4: assert property (@(posedge clk) disable iff (rst)
      (req_ready[p] && req_valid[p] && !req_grant[p]) |=> !req_ready[p]);

    // R6: a response follows a grant to the same port
    p_rsp_origin_r6: assert property (@(posedge clk) disable iff (rst)
      rsp_valid[p] |-> $past(req_grant[p]));
  end
endmodule

bind ilv_bank_front ilv_bank_front_chk #(.NPORT(NPORT), .NBANK(NBANK)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_grant(req_grant),
  .rsp_valid(rsp_valid),
  .bk_valid (bk_valid)
);

// File: tb/ilv_bank_front_tb.sv
module ilv_bank_front_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  req_valid = '0;
  logic [31:0] req_addr  = '0;
  logic [1:0]  req_we    = '0;
  logic [63:0] req_wdata = '0;
  logic [1:0]  req_ready, req_grant, rsp_valid;
  logic [63:0] rsp_data;
  logic [3:0]  bk_valid, bk_we;
  logic [31:0] bk_idx;
  logic [127:0] bk_wdata;
  logic [3:0]  bk_port;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  ilv_bank_front u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_we(req_we),
    .req_wdata(req_wdata), .req_ready(req_ready), .req_grant(req_grant),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .bk_valid(bk_valid), .bk_we(bk_we), .bk_idx(bk_idx),
    .bk_wdata(bk_wdata), .bk_port(bk_port)
  );

  typedef struct packed {
    logic v0; logic [15:0] a0; logic w0; logic [31:0] d0;
    logic v1; logic [15:0] a1; logic w1; logic [31:0] d1;
    logic g0; logic g1; logic r1; logic [3:0] bk;
    logic rv0; logic [31:0] rd0; logic rv1; logic [31:0] rd1;
  } vec_t;

  // address = {index[7:0], bank[1:0], offset[5:0]}
  localparam vec_t VEC [9] = '{
    '{1'b1,16'h0100,1'b1,32'h11, 1'b1,16'h0140,1'b1,32'h22, 1'b1,1'b1,1'b1,4'b0011, 1'b0,32'h0, 1'b0,32'h0},
    '{1'b1,16'h0380,1'b1,32'h33, 1'b1,16'h0480,1'b1,32'h44, 1'b1,1'b0,1'b1,4'b0100, 1'b0,32'h0, 1'b0,32'h0},
    '{1'b0,16'h0000,1'b0,32'h0,  1'b1,16'h0100,1'b1,32'h99, 1'b0,1'b1,1'b0,4'b0100, 1'b0,32'h0, 1'b0,32'h0},
    '{1'b1,16'h0100,1'b0,32'h0,  1'b1,16'h0480,1'b0,32'h0,  1'b1,1'b1,1'b1,4'b0101, 1'b1,32'h11, 1'b1,32'h44},
    '{1'b1,16'h0384,1'b0,32'h0,  1'b1,16'h0140,1'b0,32'h0,  1'b1,1'b1,1'b1,4'b0110, 1'b1,32'h33, 1'b1,32'h22},
    '{1'b1,16'h0140,1'b0,32'h0,  1'b1,16'h0540,1'b1,32'h55, 1'b1,1'b0,1'b1,4'b0010, 1'b1,32'h22, 1'b0,32'h0},
    '{1'b1,16'h0140,1'b0,32'h0,  1'b0,16'h0000,1'b0,32'h0,  1'b1,1'b0,1'b0,4'b0010, 1'b1,32'h22, 1'b0,32'h0},
    '{1'b0,16'h0000,1'b0,32'h0,  1'b0,16'h0000,1'b0,32'h0,  1'b0,1'b1,1'b0,4'b0010, 1'b0,32'h0, 1'b0,32'h0},
    '{1'b0,16'h0000,1'b0,32'h0,  1'b1,16'h0540,1'b0,32'h0,  1'b0,1'b1,1'b1,4'b0010, 1'b0,32'h0, 1'b1,32'h55}
  };

  task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic check_rsp(input vec_t v);
    chk("R6 rsp_valid p0", 64'(rsp_valid[0]), 64'(v.rv0));
    chk("R6 rsp_valid p1 / R10", 64'(rsp_valid[1]), 64'(v.rv1));
    if (v.rv0) chk("R7 rsp_data p0", 64'(rsp_data[31:0]), 64'(v.rd0));
    if (v.rv1) chk("R5 R7 rsp_data p1", 64'(rsp_data[63:32]), 64'(v.rd1));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8 ready in reset", 64'(req_ready), 64'h3);
    chk("R8 no bank cmd in reset", 64'(bk_valid), 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 ready after reset", 64'(req_ready), 64'h3);
    chk("R8 no rsp after reset", 64'(rsp_valid), 64'h0);
    chk("R8 no grant after reset", 64'(req_grant), 64'h0);

    // table walk: R2 R3 R4 R5 R6 R7 R9 R10
    for (int i = 0; i < 9; i++) begin
      if (i > 0) check_rsp(VEC[i-1]);
      req_valid = {VEC[i].v1, VEC[i].v0};
      req_addr  = {VEC[i].a1, VEC[i].a0};
      req_we    = {VEC[i].w1, VEC[i].w0};
      req_wdata = {VEC[i].d1, VEC[i].d0};
      #1;
      chk("R3 grant p0", 64'(req_grant[0]), 64'(VEC[i].g0));
      chk("R2 R3 R4 grant p1", 64'(req_grant[1]), 64'(VEC[i].g1));
      chk("R4 ready p1", 64'(req_ready[1]), 64'(VEC[i].r1));
      chk("R9 bank mask", 64'(bk_valid), 64'(VEC[i].bk));
      @(negedge clk);
    end
    req_valid = '0;
    check_rsp(VEC[8]);

    // R1: bank field and index, offset bits ignored
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      req_valid = 2'b01;
      req_we    = 2'b01;
      req_addr  = {16'h0, 8'h05, 2'(b), 6'h2A};
      req_wdata = {32'h0, 32'hB0 + 32'(b)};
      #1;
      chk("R1 bank select", 64'(bk_valid), 64'(4'b1 << b));
      chk("R1 bank index", 64'(bk_idx[b*8 +: 8]), 64'h05);
      chk("R9 bank we", 64'(bk_we[b]), 64'h1);
      chk("R9 bank port p0", 64'(bk_port[b]), 64'h0);
      chk("R9 bank wdata", 64'(bk_wdata[b*32 +: 32]), 64'hB0 + 64'(b));
    end

    // R9: port 1 alone, read with different offset in the same block
    @(negedge clk);
    req_valid = 2'b10;
    req_we    = 2'b00;
    req_addr  = {16'h0591, 16'h0};
    #1;
    chk("R2 lone p1 grant", 64'(req_grant), 64'h2);
    chk("R9 bank port p1", 64'(bk_port[2]), 64'h1);
    chk("R1 bank of 0x0591", 64'(bk_valid), 64'h4);
    @(negedge clk);
    req_valid = '0;
    chk("R6 rsp_valid p1 late", 64'(rsp_valid), 64'h2);
    chk("R1 R7 rsp_data p1", 64'(rsp_data[63:32]), 64'hB2);

    done = 1'b1;
    finish_run();
  end
endmodule